// File: doc/BRIEF.md
# Stall Protection Shutdown Timer

This block supervises the speed loop of a motor and removes low-side drive when the loop stays out of lock for too long while the motor is commanded to run. A programmable count of timebase strobes replaces the capacitor timing of an analog part: every strobe taken while the motor runs unlocked advances a counter. The counter reaches the programmed limit only if the loop stays unlocked without a break. At that point the drive-disable output latches on. A missing reference clock leaves the loop permanently unlocked, so the same path also cuts drive when the reference clock is lost.

The latched shutdown clears only when the run command is withdrawn or the block is reset. While the speed loop brakes by switching its reference clock, the count is held at zero. The same strobe timebase produces a power-up initial reset pulse that lasts a fixed number of strobes. During that pulse all of the supervision logic is held cleared. A build parameter can remove the protection entirely.

Top module: `stall_guard`

## Requirements
- R1: `run_n` is active low: 0 means run. While `run_n` is 1 no count accumulates, so `drive_off` cannot set however long `unlocked` stays high.
- R2: In run, with `unlocked`=1 and `clk_brake`=0, the `tick` strobe sampled on `limit` consecutive qualifying rising clock edges sets `drive_off` at the last of those edges. Only edges with `tick`=1 count; after `limit`-1 such strobes `drive_off` is still 0. A lost reference clock reaches this path because it holds `unlocked` high.
- R3: Any clock edge with `unlocked`=0 clears the accumulated count, so counting restarts from zero.
- R4: Any clock edge with `clk_brake`=1 clears the count, so no trip can happen while braking by clock switching.
- R5: Once set, `drive_off` stays 1 while `run_n` stays 0, whatever `unlocked`, `clk_brake` and `tick` do.
- R6: A clock edge with `run_n`=1 clears `drive_off`, so it reads 0 on the following cycle. An active-low `rst_n` also clears it.
- R7: `trip_pulse` is 1 for exactly the one cycle in which `drive_off` goes from 0 to 1.
- R8: After `rst_n` releases, `init_rst` is 1 until the 16th `tick` strobe. It reads 0 after that edge. While `init_rst` is 1 the count stays at zero and `drive_off` stays 0.
- R9: `limit`=0 acts like `limit`=1: the first qualifying strobe trips.
- R10: With the parameter `PROTECT_EN`=0, `drive_off` and `trip_pulse` never assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_n | input | 1 | Run command, 0 = run, 1 = stop |
| unlocked | input | 1 | Speed loop is out of lock |
| clk_brake | input | 1 | Braking by reference clock switching in progress |
| tick | input | 1 | Timebase strobe, one cycle wide |
| limit | input | 24 | Timeout in strobes |
| drive_off | output | 1 | Latched low-side drive disable |
| trip_pulse | output | 1 | One-cycle flag marking a trip |
| init_rst | output | 1 | Power-up initial reset pulse |

## Verification
The hardest state to reach from the ports is a count that sits one strobe short of the limit and is then interrupted. The interruption can be a single-cycle drop of `unlocked` or the start of brake mode. The bench runs an unlocked stretch part-way, inserts a one-cycle lock between strobes, and shows that the trip needs a full new run of strobes. A trip followed by lock, brake and more strobes shows that the latch does not depend on the inputs that set it.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int unsigned LIMIT_W    = 24;
  localparam int unsigned INIT_TICKS = 16;

  // True when one more strobe brings the count to the limit (limit 0 acts as 1).
  function automatic logic limit_hit(input logic [LIMIT_W-1:0] cnt,
                                     input logic [LIMIT_W-1:0] lim);
    logic [LIMIT_W:0] nxt;
    nxt = {1'b0, cnt} + {{LIMIT_W{1'b0}}, 1'b1};
    return (lim == '0) || (nxt >= {1'b0, lim});
  endfunction
endpackage

// File: rtl/stall_por.sv
module stall_por #(
  parameter int unsigned TICKS = stall_pkg::INIT_TICKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic busy
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy && tick) begin
      if (cnt_q == LAST) busy <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/stall_timer.sv
module stall_timer #(
  parameter int unsigned W = stall_pkg::LIMIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] lim,
  output logic         hit_evt
);
  logic [W-1:0] cnt_q;
  logic         at_lim;

  assign at_lim  = stall_pkg::limit_hit(cnt_q, lim);
  assign hit_evt = !clr && tick && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (tick && !at_lim)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/stall_latch.sv
module stall_latch #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_evt,
  output logic latched,
  output logic set_pulse
);
  generate
    if (ENABLE) begin : g_on
      logic lat_q, pls_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lat_q <= 1'b0;
          pls_q <= 1'b0;
        end else if (clr) begin
          lat_q <= 1'b0;
          pls_q <= 1'b0;
        end else begin
          pls_q <= set_evt && !lat_q;
          if (set_evt) lat_q <= 1'b1;
        end
      end
      assign latched   = lat_q;
      assign set_pulse = pls_q;
    end else begin : g_off
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ clr ^ set_evt;
      assign latched   = 1'b0;
      assign set_pulse = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/stall_guard.sv
module stall_guard #(
  parameter bit          PROTECT_EN = 1'b1,
  parameter int unsigned LIMIT_W    = stall_pkg::LIMIT_W,
  parameter int unsigned INIT_TICKS = stall_pkg::INIT_TICKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_n,
  input  logic               unlocked,
  input  logic               clk_brake,
  input  logic               tick,
  input  logic [LIMIT_W-1:0] limit,
  output logic               drive_off,
  output logic               trip_pulse,
  output logic               init_rst
);
  logic por_busy;
  logic cnt_clr;
  logic trip_evt;
  logic latch_clr;

  stall_por #(.TICKS(INIT_TICKS)) u_por (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(por_busy)
  );

  assign cnt_clr   = por_busy || run_n || !unlocked || clk_brake;
  assign latch_clr = por_busy || run_n;

  stall_timer #(.W(LIMIT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick),
    .lim(limit), .hit_evt(trip_evt)
  );

  stall_latch #(.ENABLE(PROTECT_EN)) u_lat (
    .clk(clk), .rst_n(rst_n), .clr(latch_clr), .set_evt(trip_evt),
    .latched(drive_off), .set_pulse(trip_pulse)
  );

  assign init_rst = por_busy;
endmodule

// File: rtl/stall_guard_chk.sv
module stall_guard_chk #(
  parameter bit PROTECT_EN = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic run_n,
  input logic unlocked,
  input logic clk_brake,
  input logic tick,
  input logic trip_evt,
  input logic drive_off,
  input logic trip_pulse,
  input logic init_rst
);
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> !drive_off); // R6
  AST_STOP_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |-> !trip_evt); // R1
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_off && !run_n) |=> drive_off); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse |=> !trip_pulse); // R7
  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_off) |-> trip_pulse); // R7
  AST_RISE_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_off) |-> ($past(unlocked) && $past(tick))); // R2
  AST_BRAKE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_off) |-> !$past(clk_brake)); // R4
  AST_INIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    init_rst |-> !drive_off); // R8
  AST_INIT_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    !init_rst |=> !init_rst); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !PROTECT_EN |-> (!drive_off && !trip_pulse)); // R10
endmodule

bind stall_guard stall_guard_chk #(.PROTECT_EN(PROTECT_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_n(run_n), .unlocked(unlocked),
  .clk_brake(clk_brake), .tick(tick), .trip_evt(trip_evt),
  .drive_off(drive_off), .trip_pulse(trip_pulse), .init_rst(init_rst)
);

// File: tb/sim_stall_guard.sv
`timescale 1ns/1ps
module sim_stall_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_n = 1'b1;
  logic unlocked = 1'b0;
  logic clk_brake = 1'b0;
  logic tick = 1'b0;
  logic [23:0] limit = 24'd5;
  logic drive_off, trip_pulse, init_rst;
  logic drive_off_d, trip_pulse_d, init_rst_d;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stall_guard u0 (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .unlocked(unlocked),
    .clk_brake(clk_brake), .tick(tick), .limit(limit),
    .drive_off(drive_off), .trip_pulse(trip_pulse), .init_rst(init_rst)
  );

  stall_guard #(.PROTECT_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .unlocked(unlocked),
    .clk_brake(clk_brake), .tick(tick), .limit(limit),
    .drive_off(drive_off_d), .trip_pulse(trip_pulse_d), .init_rst(init_rst_d)
  );

  // {limit[23:0], ticks[7:0], unlocked, brake, expected drive_off}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {24'd5,   8'd5,   1'b1, 1'b0, 1'b1},
    {24'd5,   8'd4,   1'b1, 1'b0, 1'b0},
    {24'd5,   8'd5,   1'b0, 1'b0, 1'b0},
    {24'd5,   8'd6,   1'b1, 1'b1, 1'b0},
    {24'd1,   8'd1,   1'b1, 1'b0, 1'b1},
    {24'd0,   8'd1,   1'b1, 1'b0, 1'b1},
    {24'd3,   8'd10,  1'b1, 1'b0, 1'b1},
    {24'd200, 8'd199, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic stop_cycle();
    run_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R8 reset init_rst", init_rst, 1'b1);
    check("R6 reset drive_off", drive_off, 1'b0);
    check("R7 reset trip_pulse", trip_pulse, 1'b0);
    rst_n = 1'b1;
    run_n = 1'b0; unlocked = 1'b1; limit = 24'd5;
    @(negedge clk);
    pulse_ticks(15);
    check("R8 init after 15 ticks", init_rst, 1'b1);
    check("R8 held during init", drive_off, 1'b0);
    pulse_ticks(1);
    check("R8 init after 16 ticks", init_rst, 1'b0);
    check("R8 no trip from init ticks", drive_off, 1'b0);

    // vector table (R2 R3 R4 R9)
    for (int v = 0; v < NV; v++) begin
      stop_cycle();
      check("R6 clear before vector", drive_off, 1'b0);
      limit = VEC[v][34:11];
      unlocked = VEC[v][2];
      clk_brake = VEC[v][1];
      run_n = 1'b0;
      @(negedge clk);
      pulse_ticks(int'(VEC[v][10:3]));
      check("R2/R3/R4/R9 vector", drive_off, VEC[v][0]);
      check("R10 disabled instance", drive_off_d, 1'b0);
    end
    clk_brake = 1'b0;

    // R2: non-strobe cycles do not count; R7 pulse width
    stop_cycle();
    limit = 24'd4; unlocked = 1'b1; run_n = 1'b0;
    repeat (20) @(negedge clk);
    pulse_ticks(3);
    check("R2 idle cycles not counted", drive_off, 1'b0);
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
    check("R2 trip at limit", drive_off, 1'b1);
    check("R7 pulse on trip", trip_pulse, 1'b1);
    @(negedge clk);
    check("R7 pulse one cycle", trip_pulse, 1'b0);
    // R5 latch holds through lock, brake, more ticks
    unlocked = 1'b0; clk_brake = 1'b1;
    pulse_ticks(3);
    check("R5 latch holds", drive_off, 1'b1);
    check("R7 no second pulse", trip_pulse, 1'b0);
    check("R10 disabled no pulse", trip_pulse_d, 1'b0);
    clk_brake = 1'b0;
    stop_cycle();
    check("R6 stop clears", drive_off, 1'b0);

    // R3: one-cycle lock glitch restarts the count
    limit = 24'd5; unlocked = 1'b1; run_n = 1'b0;
    @(negedge clk);
    pulse_ticks(4);
    unlocked = 1'b0;
    @(negedge clk);
    unlocked = 1'b1;
    pulse_ticks(4);
    check("R3 glitch restarts count", drive_off, 1'b0);
    pulse_ticks(1);
    check("R3 trip after full rerun", drive_off, 1'b1);

    // R4: brake mid-run restarts the count
    stop_cycle();
    run_n = 1'b0;
    @(negedge clk);
    pulse_ticks(4);
    clk_brake = 1'b1;
    @(negedge clk);
    clk_brake = 1'b0;
    pulse_ticks(4);
    check("R4 brake restarts count", drive_off, 1'b0);

    // R1: stop with loop unlocked never trips
    run_n = 1'b1; limit = 24'd2;
    pulse_ticks(10);
    check("R1 no trip in stop", drive_off, 1'b0);
    check("R1 no pulse in stop", trip_pulse, 1'b0);

    // R6: reset clears a latched trip and restarts init pulse
    run_n = 1'b0;
    pulse_ticks(2);
    check("R2 trip before reset", drive_off, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R6 reset clears latch", drive_off, 1'b0);
    check("R8 reset restarts init", init_rst, 1'b1);
    rst_n = 1'b1;
    pulse_ticks(16);
    check("R8 init ends again", init_rst, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule